// File: doc/BRIEF.md
# LPC I/O Target Cycle Engine

This block is the target side of a Low Pin Count bus. It follows host cycles on the 4-bit multiplexed address/data lines. An active-low frame strobe marks the start of each cycle. The block acts only on single-byte I/O read and I/O write cycles whose 16-bit address falls inside a window set by parameters. For those cycles it drives the turnaround and sync nibbles. It fetches read data from, or delivers write data to, a local register port.

The local register port carries plain strobes and has no back-pressure:
- The register file must present `reg_rdata` combinationally in the cycle `reg_rd` is high. The block latches it at the end of that cycle.
- `reg_wr` is a one-cycle pulse with `reg_addr` and `reg_wdata` valid in the same cycle. The register file must accept the write in that cycle.

The block ignores unsupported cycle types and addresses outside the window, and never drives the bus for them. If the frame strobe is asserted in the middle of a cycle, the block releases the bus on the next clock and looks for a new start. The `idle` output is high whenever no cycle is being decoded, so the surrounding logic can gate clocks.

Top module: `lpc_io_target`

## Requirements
- R1: After reset, `idle` is 1, `lad_oe` is 0, and `reg_rd` and `reg_wr` are 0.
- R2: A cycle starts only on a clock where `frame_n` is 0 and `lad_in` is 4'b0000. A frame-low clock carrying any other nibble leaves the block idle.
- R3: Cycle type 4'b0010 is an I/O write. The block takes the address as four nibbles, most significant first, then the data as two nibbles, low nibble first, then two host turnaround clocks. In the next clock `reg_wr` pulses once with the full address and byte.
- R4: Cycle type 4'b0000 is an I/O read. After the address and the two host turnaround clocks, `reg_rd` pulses for one clock. The two data nibbles are driven low nibble first, right after the ready sync.
- R5: Each accepted cycle drives exactly one short-wait sync nibble 4'b0101, followed on the next clock by the ready sync 4'b0000.
- R6: The target turnaround is one clock driving 4'b1111 with `lad_oe` high, then one clock with `lad_oe` low. After that the block is idle.
- R7: Any cycle-type nibble other than 4'b0000 or 4'b0010 is ignored: no bus drive and no strobes for the rest of that cycle.
- R8: The address matches when `(addr & WIN_MASK) == (WIN_BASE & WIN_MASK)`. The defaults are base 16'h0300 and mask 16'hFFF0. On a mismatch the block returns to idle with no bus drive and no strobes.
- R9: When `frame_n` is sampled 0 in the middle of a cycle, `lad_oe` is 0 from the next clock. A new cycle can start on that same frame-low clock.
- R10: `idle` is 1 exactly when no cycle is being decoded, and `lad_oe` is never 1 while `idle` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble sampled from the bus |
| lad_out | output | 4 | Nibble the target drives |
| lad_oe | output | 1 | Output enable for lad_out |
| idle | output | 1 | High when no cycle is in progress |
| reg_addr | output | 16 | Local register address |
| reg_wdata | output | 8 | Local write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Local read data, valid while reg_rd is high |

## Verification
The assertions check the following on every cycle:
- a write strobe is never followed by another write strobe;
- a read strobe is always followed by the driven ready sync;
- the bus is released after the driven turnaround clock and on the clock after any frame-low sample;
- the bus is never driven while idle.

Only the directed scenarios can show the rest:
- the exact nibble order of address and data;
- the sync codes and the values returned;
- that unsupported types, out-of-window addresses and non-start frame nibbles leave the bus untouched;
- that a cycle restarted right after an abort still completes.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;
  localparam logic [3:0] NIB_START   = 4'b0000;
  localparam logic [3:0] TYPE_IO_RD  = 4'b0000;
  localparam logic [3:0] TYPE_IO_WR  = 4'b0010;
  localparam logic [3:0] SYNC_SHORT  = 4'b0101;
  localparam logic [3:0] SYNC_READY  = 4'b0000;
  localparam logic [3:0] TAR_DRIVE   = 4'b1111;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTYPE,
    ST_ADDR,
    ST_WDATA,
    ST_HTAR,
    ST_SWAIT,
    ST_SRDY,
    ST_RDATA,
    ST_TTAR1,
    ST_TTAR2
  } lpc_state_e;
endpackage

// File: rtl/lpc_addr_match.sv
module lpc_addr_match #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] WIN_BASE = 16'h0300,
  parameter logic [15:0] WIN_MASK = 16'hFFF0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] BASE_M = ADDR_W'(WIN_BASE & WIN_MASK);
  localparam logic [ADDR_W-1:0] MASK_W = ADDR_W'(WIN_MASK);

  always_comb hit = ((addr & MASK_W) == BASE_M);
endmodule

// File: rtl/lpc_cycle_fsm.sv
module lpc_cycle_fsm
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  input  logic              addr_hit,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] addr_next,
  output lpc_state_e        state,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              reg_wr,
  output logic              reg_rd
);
  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int DATA_NIBS = DATA_W / 4;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);
  localparam logic [CNT_W-1:0] TAR_LAST  = CNT_W'(1);

  logic is_wr;

  always_comb addr_next = {addr_q[ADDR_W-5:0], lad_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      is_wr   <= 1'b0;
    end else if (!frame_n) begin
      cnt   <= '0;
      state <= (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: state <= ST_IDLE;
        ST_CTYPE: begin
          cnt <= '0;
          if (lad_in == TYPE_IO_RD) begin
            is_wr <= 1'b0;
            state <= ST_ADDR;
          end else if (lad_in == TYPE_IO_WR) begin
            is_wr <= 1'b1;
            state <= ST_ADDR;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_ADDR: begin
          addr_q <= addr_next;
          if (cnt == ADDR_LAST) begin
            cnt <= '0;
            if (!addr_hit)  state <= ST_IDLE;
            else if (is_wr) state <= ST_WDATA;
            else            state <= ST_HTAR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WDATA: begin
          wdata_q[cnt*4 +: 4] <= lad_in;
          if (cnt == DATA_LAST) begin
            cnt   <= '0;
            state <= ST_HTAR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HTAR: begin
          if (cnt == TAR_LAST) begin
            cnt   <= '0;
            state <= ST_SWAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SWAIT: begin
          if (!is_wr) rdata_q <= reg_rdata;
          state <= ST_SRDY;
        end
        ST_SRDY: begin
          cnt   <= '0;
          state <= is_wr ? ST_TTAR1 : ST_RDATA;
        end
        ST_RDATA: begin
          if (cnt == DATA_LAST) begin
            cnt   <= '0;
            state <= ST_TTAR1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TTAR1: state <= ST_TTAR2;
        ST_TTAR2: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_wr = (state == ST_SWAIT) &&  is_wr;
    reg_rd = (state == ST_SWAIT) && !is_wr;
  end

  assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
endmodule

// File: rtl/lpc_lad_driver.sv
module lpc_lad_driver
  import lpc_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2
) (
  input  lpc_state_e        state,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] rdata_q,
  output logic [3:0]        lad_out,
  output logic              lad_oe
);
  always_comb begin
    lad_oe  = 1'b0;
    lad_out = 4'b0000;
    unique case (state)
      ST_SWAIT: begin lad_oe = 1'b1; lad_out = SYNC_SHORT; end
      ST_SRDY:  begin lad_oe = 1'b1; lad_out = SYNC_READY; end
      ST_RDATA: begin lad_oe = 1'b1; lad_out = rdata_q[cnt*4 +: 4]; end
      ST_TTAR1: begin lad_oe = 1'b1; lad_out = TAR_DRIVE; end
      default:  begin lad_oe = 1'b0; lad_out = 4'b0000; end
    endcase
  end
endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
  import lpc_tgt_pkg::*;
#(
  parameter logic [15:0] WIN_BASE = 16'h0300,
  parameter logic [15:0] WIN_MASK = 16'hFFF0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic [3:0]  lad_in,
  output logic [3:0]  lad_out,
  output logic        lad_oe,
  output logic        idle,
  output logic [15:0] reg_addr,
  output logic [7:0]  reg_wdata,
  output logic        reg_wr,
  output logic        reg_rd,
  input  logic [7:0]  reg_rdata
);
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(ADDR_W / 4);

  lpc_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_next;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              hit;

  lpc_addr_match #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK)) u_match (
    .addr (addr_next),
    .hit  (hit)
  );

  lpc_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .lad_in    (lad_in),
    .addr_hit  (hit),
    .reg_rdata (reg_rdata),
    .addr_next (addr_next),
    .state     (state),
    .cnt       (cnt),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .rdata_q   (rdata_q),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd)
  );

  lpc_lad_driver #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_drv (
    .state   (state),
    .cnt     (cnt),
    .rdata_q (rdata_q),
    .lad_out (lad_out),
    .lad_oe  (lad_oe)
  );

  always_comb begin
    idle      = (state == ST_IDLE);
    reg_addr  = addr_q;
    reg_wdata = wdata_q;
  end

  assert_ready_after_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && frame_n) |=> (lad_oe && lad_out == SYNC_READY));
  assert_release_after_tar_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TTAR1 && frame_n) |=> !lad_oe);
  assert_abort_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !lad_oe);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !lad_oe);
endmodule

// File: tb/lpc_io_target_test.sv
module lpc_io_target_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        idle;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic        reg_wr;
  logic        reg_rd;
  logic [7:0]  reg_rdata;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  bit oe_seen = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lpc_io_target uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .idle(idle), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] rd_model(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  always_comb reg_rdata = rd_model(reg_addr);

  always @(posedge clk) begin
    if (reg_wr) wr_cnt <= wr_cnt + 1;
    if (reg_rd) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic f, input logic [3:0] l);
    frame_n = f;
    lad_in  = l;
    @(posedge clk);
    @(negedge clk);
    if (lad_oe) oe_seen = 1'b1;
  endtask

  task automatic send_head(input logic [3:0] ctype, input logic [15:0] a);
    tick(1'b0, 4'h0);
    tick(1'b1, ctype);
    for (int i = 3; i >= 0; i--) tick(1'b1, a[i*4 +: 4]);
  endtask

  task automatic t_reset();
    chk(idle == 1'b1, "R1 idle", idle, 1);
    chk(lad_oe == 1'b0, "R1 oe", lad_oe, 0);
    chk(reg_rd == 1'b0 && reg_wr == 1'b0, "R1 strobes", {reg_rd, reg_wr}, 0);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [7:0] d);
    int w0 = wr_cnt;
    send_head(4'b0010, a);
    tick(1'b1, d[3:0]);
    tick(1'b1, d[7:4]);
    tick(1'b1, 4'hF);
    tick(1'b1, 4'hF);
    chk(reg_wr == 1'b1, "R3 wr strobe", reg_wr, 1);
    chk(reg_addr == a, "R3 addr", reg_addr, a);
    chk(reg_wdata == d, "R3 data", reg_wdata, d);
    chk(lad_oe && lad_out == 4'h5, "R5 short sync", lad_out, 5);
    tick(1'b1, 4'hF);
    chk(lad_oe && lad_out == 4'h0, "R5 ready sync", lad_out, 0);
    chk(reg_wr == 1'b0, "R3 single pulse", reg_wr, 0);
    tick(1'b1, 4'hF);
    chk(lad_oe && lad_out == 4'hF, "R6 tar drive", lad_out, 4'hF);
    tick(1'b1, 4'hF);
    chk(!lad_oe && !idle, "R6 tar float", {lad_oe, idle}, 0);
    tick(1'b1, 4'hF);
    chk(idle == 1'b1, "R10 idle after write", idle, 1);
    chk(wr_cnt == w0 + 1, "R3 write count", wr_cnt - w0, 1);
  endtask

  task automatic t_read(input logic [15:0] a);
    logic [7:0] e = rd_model(a);
    send_head(4'b0000, a);
    chk(!idle && !lad_oe, "R10 busy while host drives", {idle, lad_oe}, 0);
    tick(1'b1, 4'hF);
    tick(1'b1, 4'hF);
    chk(reg_rd == 1'b1 && reg_addr == a, "R4 rd strobe", reg_addr, a);
    chk(lad_oe && lad_out == 4'h5, "R5 short sync rd", lad_out, 5);
    tick(1'b1, 4'hF);
    chk(lad_oe && lad_out == 4'h0, "R5 ready sync rd", lad_out, 0);
    tick(1'b1, 4'hF);
    chk(lad_oe && lad_out == e[3:0], "R4 low nibble", lad_out, e[3:0]);
    tick(1'b1, 4'hF);
    chk(lad_oe && lad_out == e[7:4], "R4 high nibble", lad_out, e[7:4]);
    tick(1'b1, 4'hF);
    chk(lad_oe && lad_out == 4'hF, "R6 tar drive rd", lad_out, 4'hF);
    tick(1'b1, 4'hF);
    chk(!lad_oe, "R6 tar float rd", lad_oe, 0);
    tick(1'b1, 4'hF);
    chk(idle == 1'b1, "R10 idle after read", idle, 1);
  endtask

  task automatic t_bad_type();
    int r0 = rd_cnt;
    int w0 = wr_cnt;
    oe_seen = 1'b0;
    send_head(4'b0100, 16'h0305);
    chk(idle == 1'b1, "R7 idle on bad type", idle, 1);
    for (int i = 0; i < 8; i++) tick(1'b1, 4'h0);
    chk(!oe_seen, "R7 no drive", oe_seen, 0);
    chk(rd_cnt == r0 && wr_cnt == w0, "R7 no strobes", rd_cnt + wr_cnt, r0 + w0);
  endtask

  task automatic t_miss();
    int r0 = rd_cnt;
    int w0 = wr_cnt;
    oe_seen = 1'b0;
    send_head(4'b0000, 16'h0310);
    chk(idle == 1'b1, "R8 idle on miss", idle, 1);
    for (int i = 0; i < 8; i++) tick(1'b1, 4'hF);
    send_head(4'b0010, 16'h0203);
    for (int i = 0; i < 8; i++) tick(1'b1, 4'h0);
    chk(!oe_seen, "R8 no drive on miss", oe_seen, 0);
    chk(rd_cnt == r0 && wr_cnt == w0, "R8 no strobes on miss", rd_cnt + wr_cnt, r0 + w0);
  endtask

  task automatic t_start_rule();
    oe_seen = 1'b0;
    tick(1'b0, 4'h3);
    chk(idle == 1'b1, "R2 non-start nibble", idle, 1);
    tick(1'b1, 4'h0);
    for (int i = 0; i < 8; i++) tick(1'b1, 4'h3);
    chk(idle == 1'b1 && !oe_seen, "R2 stays idle", {idle, oe_seen}, 2);
    tick(1'b0, 4'h5);
    t_read(16'h030C);
  endtask

  task automatic t_abort();
    send_head(4'b0000, 16'h0301);
    tick(1'b1, 4'hF);
    tick(1'b1, 4'hF);
    tick(1'b1, 4'hF);
    tick(1'b1, 4'hF);
    chk(lad_oe == 1'b1, "R9 driving before abort", lad_oe, 1);
    tick(1'b0, 4'hF);
    chk(!lad_oe && idle, "R9 released after abort", {lad_oe, idle}, 1);
    t_write(16'h030E, 8'hC3);
    send_head(4'b0010, 16'h0302);
    tick(1'b1, 4'h1);
    tick(1'b0, 4'h0);
    chk(!lad_oe && !idle, "R9 restart on frame", {lad_oe, idle}, 0);
    tick(1'b1, 4'b0000);
    for (int i = 3; i >= 0; i--) tick(1'b1, 4'(16'h0307 >> (i*4)));
    tick(1'b1, 4'hF);
    tick(1'b1, 4'hF);
    chk(reg_rd == 1'b1 && reg_addr == 16'h0307, "R9 new cycle after abort", reg_addr, 16'h0307);
    for (int i = 0; i < 6; i++) tick(1'b1, 4'hF);
    chk(idle == 1'b1, "R10 idle after restarted cycle", idle, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(16'h0304, 8'h96);
    t_write(16'h030F, 8'h1E);
    t_read(16'h0300);
    t_read(16'h030B);
    t_bad_type();
    t_miss();
    t_start_rule();
    t_abort();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule